// File: doc/BRIEF.md
# Comparator-Driven Debug Trigger Sequencer

This block is the sequencing stage of an on-chip debug unit. Three comparator match pulses come in, one per channel. The block walks through three intermediate states before it reaches a terminal state, and on that step it raises a one-cycle trigger that a break or capture unit can act on. The comparators, trace storage and processor break handling are outside the block.

Each intermediate state has its own 4-bit control word. A fixed table turns that word into a next state for each channel, or into no move for that channel. When matches arrive in the same cycle, a resolver picks the winner. Any match that leads to the terminal state wins. Otherwise the lowest-numbered channel wins. This rule lets two comparators detect an event that occurs twice in a row with no other event between the two.

A range-mode flag models channel 0 doing a range compare, which uses up channel 1. While the flag is set, channel 1 matches have no effect.

Top module: `dbg_seq_top`

## Requirements
- R1: After reset, state_o is 0 (idle) and trigger_o is 0. The state codes are: idle=0, first stage=1, second stage=2, third stage=3, terminal=4.
- R2: While arm is low, the state goes to idle (0) at the next clock edge and trigger_o stays 0, whatever the matches are. When arm is high in idle, the state goes to the first stage (1) at the next edge, and matches seen in idle are ignored.
- R3: Each stage uses its own control word: ctrl_s1 in stage 1, ctrl_s2 in stage 2 and ctrl_s3 in stage 3. The control-word table is: 0001 m0->2; 0010 m1->2; 0011 m2->2; 0100 m0->3; 0101 m1->3; 0110 m2->3; 0111 m0->4; 1000 m1->4; 1001 m2->4; 1010 m0->2 and m2->4; 1011 m0->4 and m2->2; 1100 m0->3 and m2->2; 1101 m0->3 and m2->4; 1110 every channel ->4. A channel that is not listed for a word causes no move.
- R4: When several effective matches arrive in the same cycle and any of them leads to terminal, the sequencer goes to terminal.
- R5: When several effective matches arrive together and none of them leads to terminal, the lowest-numbered channel decides the next state.
- R6: While range_mode is 1, a match on channel 1 (match[1]) never causes a transition.
- R7: trigger_o is high for exactly the one cycle in which state_o first shows terminal. It rises at the same edge that moves the state into terminal.
- R8: Once the sequencer is in terminal with arm high, it stays there and ignores all matches. It restarts from stage 1 only after arm goes low and then high again.
- R9: Control words 0000 and 1111, and channels a word does not map, leave the state unchanged.
- R10: A match present before a clock edge takes effect at that edge, so a single-cycle pulse moves the state one step.
- R11: Two consecutive occurrences of the same event (channel 0 or channel 2) with no occurrence of the other event between them reach terminal. An alternating pattern of the two events does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Enables the sequencer; when low, the sequencer returns to idle |
| match | input | 3 | Comparator match pulses; bit i is channel i |
| range_mode | input | 1 | When 1, channel 1 is disabled |
| ctrl_s1 | input | 4 | Control word for stage 1 |
| ctrl_s2 | input | 4 | Control word for stage 2 |
| ctrl_s3 | input | 4 | Control word for stage 3 |
| state_o | output | 3 | Current state code |
| trigger_o | output | 1 | One-cycle pulse on entry to terminal |

## Verification
The key corner is stage 3 mapping m0 back to stage 2 while m2 goes to terminal, with both pulses arriving in one cycle. A resolver that applied only lowest-channel priority would fall back to stage 2 and never fire. The bench also drives the two-event patterns: a repeated event must fire, and an alternating pattern must not. A wrong priority order, or a table row that is wrong, would either miss the repeat or fire on the alternating pattern. Further checks cover channel 1 during range mode, matches arriving after terminal, and disarming part-way through a sequence. A design that got these wrong would move on a masked match, trigger a second time, or carry on without a restart.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_FIN  = 3'd4
  } seq_state_t;

  // Next state for channel ch under control word code; ST_IDLE means "no move".
  function automatic seq_state_t seq_target(input logic [3:0] code, input int ch);
    seq_state_t t0, t1, t2;
    t0 = ST_IDLE; t1 = ST_IDLE; t2 = ST_IDLE;
    case (code)
      4'b0001: t0 = ST_S2;
      4'b0010: t1 = ST_S2;
      4'b0011: t2 = ST_S2;
      4'b0100: t0 = ST_S3;
      4'b0101: t1 = ST_S3;
      4'b0110: t2 = ST_S3;
      4'b0111: t0 = ST_FIN;
      4'b1000: t1 = ST_FIN;
      4'b1001: t2 = ST_FIN;
      4'b1010: begin t0 = ST_S2;  t2 = ST_FIN; end
      4'b1011: begin t0 = ST_FIN; t2 = ST_S2;  end
      4'b1100: begin t0 = ST_S3;  t2 = ST_S2;  end
      4'b1101: begin t0 = ST_S3;  t2 = ST_FIN; end
      4'b1110: begin t0 = ST_FIN; t1 = ST_FIN; t2 = ST_FIN; end
      default: ;
    endcase
    case (ch)
      0:       return t0;
      1:       return t1;
      2:       return t2;
      default: return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/dbg_seq_resolve.sv
module dbg_seq_resolve
  import dbg_seq_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CTRL_W = 4,
  parameter int RANGE_CH = 1
) (
  input  logic [CTRL_W-1:0] code,
  input  logic [NUM_CH-1:0] match,
  input  logic              range_mode,
  output logic              hit,
  output logic              fin_hit,
  output seq_state_t        win
);

  seq_state_t        tgt   [NUM_CH];
  logic [NUM_CH-1:0] valid;
  logic [NUM_CH-1:0] to_fin;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign tgt[i]    = seq_target(code, i);
    assign valid[i]  = match[i] && (tgt[i] != ST_IDLE) && !(range_mode && (i == RANGE_CH));
    assign to_fin[i] = valid[i] && (tgt[i] == ST_FIN);
  end

  assign hit     = |valid;
  assign fin_hit = |to_fin;

  always_comb begin
    win = ST_IDLE;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (valid[i]) win = tgt[i];
    end
    if (fin_hit) win = ST_FIN;
  end

  always_comb begin
    if (range_mode) begin
      AST_RANGE_MASK: assert (!valid[RANGE_CH]); // R6
    end
  end

endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       hit,
  input  seq_state_t win,
  output seq_state_t state,
  output logic       trigger
);

  seq_state_t nxt;
  logic       active;

  assign active = (state == ST_S1) || (state == ST_S2) || (state == ST_S3);

  always_comb begin
    nxt = state;
    if (!arm)                nxt = ST_IDLE;
    else if (state == ST_IDLE) nxt = ST_S1;
    else if (active && hit)  nxt = win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      trigger <= 1'b0;
    end else begin
      state   <= nxt;
      trigger <= active && (nxt == ST_FIN);
    end
  end

  AST_DISARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (state == ST_IDLE) && !trigger); // R2
  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> !trigger); // R7
  AST_TRIG_IN_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> state == ST_FIN); // R7
  AST_FIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN && arm) |=> state == ST_FIN && !trigger); // R8

endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
  import dbg_seq_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [NUM_CH-1:0] match,
  input  logic              range_mode,
  input  logic [CTRL_W-1:0] ctrl_s1,
  input  logic [CTRL_W-1:0] ctrl_s2,
  input  logic [CTRL_W-1:0] ctrl_s3,
  output logic [2:0]        state_o,
  output logic              trigger_o
);

  seq_state_t        cur;
  seq_state_t        win;
  logic              hit;
  logic              fin_hit;
  logic [CTRL_W-1:0] code;

  always_comb begin
    case (cur)
      ST_S1:   code = ctrl_s1;
      ST_S2:   code = ctrl_s2;
      ST_S3:   code = ctrl_s3;
      default: code = '0;
    endcase
  end

  dbg_seq_resolve #(.NUM_CH(NUM_CH), .CTRL_W(CTRL_W)) u_res (
    .code(code), .match(match), .range_mode(range_mode),
    .hit(hit), .fin_hit(fin_hit), .win(win)
  );

  dbg_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hit(hit), .win(win),
    .state(cur), .trigger(trigger_o)
  );

  assign state_o = cur;

  AST_FIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && fin_hit && (cur == ST_S1 || cur == ST_S2 || cur == ST_S3))
      |=> (cur == ST_FIN) && trigger_o); // R4

endmodule

// File: tb/tb_dbg_seq_top.sv
module tb_dbg_seq_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm = 1'b0;
  logic [2:0] match = '0;
  logic       range_mode = 1'b0;
  logic [3:0] ctrl_s1 = '0, ctrl_s2 = '0, ctrl_s3 = '0;
  logic [2:0] state_o;
  logic       trigger_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  dbg_seq_top dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .match(match), .range_mode(range_mode),
    .ctrl_s1(ctrl_s1), .ctrl_s2(ctrl_s2), .ctrl_s3(ctrl_s3),
    .state_o(state_o), .trigger_o(trigger_o)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input logic [2:0] es, input logic et, input string req);
    checks++;
    if (state_o !== es || trigger_o !== et) begin
      failures++;
      $display("FAIL %s: state=%0d trig=%0b expected state=%0d trig=%0b",
               req, state_o, trigger_o, es, et);
    end
  endtask

  task automatic pulse(input logic [2:0] m);
    match = m;
    step();
    match = '0;
  endtask

  task automatic rearm();
    arm = 1'b0; step();
    arm = 1'b1; step();
  endtask

  task automatic t_reset();
    chk(3'd0, 1'b0, "R1 reset");
  endtask

  task automatic t_arm();
    match = 3'b111; ctrl_s1 = 4'b1110;
    step(); chk(3'd0, 1'b0, "R2 idle while disarmed");
    match = '0;
    arm = 1'b1; match = 3'b111; step(); match = '0;
    chk(3'd1, 1'b0, "R2 arm enters stage 1, idle matches ignored");
  endtask

  task automatic t_chain();
    ctrl_s1 = 4'b0001; ctrl_s2 = 4'b0101; ctrl_s3 = 4'b1001;
    rearm();
    pulse(3'b001); chk(3'd2, 1'b0, "R3 R10 m0 to stage 2");
    pulse(3'b010); chk(3'd3, 1'b0, "R3 m1 to stage 3");
    pulse(3'b100); chk(3'd4, 1'b1, "R7 m2 to terminal with trigger");
    step();        chk(3'd4, 1'b0, "R7 trigger is one cycle");
    pulse(3'b111); chk(3'd4, 1'b0, "R8 terminal ignores matches");
    arm = 1'b0; step(); chk(3'd0, 1'b0, "R2 disarm from terminal");
    arm = 1'b1; step(); chk(3'd1, 1'b0, "R8 rearm restarts");
  endtask

  task automatic t_priority();
    ctrl_s1 = 4'b1100; ctrl_s2 = 4'b1101; ctrl_s3 = 4'b1010;
    rearm();
    pulse(3'b001); chk(3'd3, 1'b0, "R3 m0 to stage 3");
    pulse(3'b101); chk(3'd4, 1'b1, "R4 simultaneous m0/m2, terminal wins");
    rearm();
    pulse(3'b101); chk(3'd3, 1'b0, "R5 lowest channel wins");
  endtask

  task automatic t_consec();
    ctrl_s1 = 4'b1100; ctrl_s2 = 4'b1101; ctrl_s3 = 4'b1011;
    rearm();
    pulse(3'b001); chk(3'd3, 1'b0, "R11 first A");
    pulse(3'b001); chk(3'd4, 1'b1, "R11 second A triggers");
    rearm();
    pulse(3'b100); chk(3'd2, 1'b0, "R11 first B");
    pulse(3'b100); chk(3'd4, 1'b1, "R11 second B triggers");
    rearm();
    pulse(3'b001); pulse(3'b100); pulse(3'b001);
    chk(3'd3, 1'b0, "R11 alternating does not trigger");
    pulse(3'b100); chk(3'd2, 1'b0, "R11 alternating stays armed");
  endtask

  task automatic t_range();
    ctrl_s1 = 4'b0010;
    rearm();
    range_mode = 1'b1;
    pulse(3'b010); chk(3'd1, 1'b0, "R6 m1 masked in range mode");
    range_mode = 1'b0;
    pulse(3'b010); chk(3'd2, 1'b0, "R6 m1 active without range mode");
  endtask

  task automatic t_nomove();
    ctrl_s1 = 4'b1111;
    rearm();
    pulse(3'b111); chk(3'd1, 1'b0, "R9 word 1111 no move");
    ctrl_s1 = 4'b0000;
    pulse(3'b111); chk(3'd1, 1'b0, "R9 word 0000 no move");
    ctrl_s1 = 4'b0001;
    pulse(3'b110); chk(3'd1, 1'b0, "R9 unmapped channel no move");
  endtask

  task automatic t_disarm_mid();
    ctrl_s1 = 4'b0001; ctrl_s2 = 4'b0111;
    rearm();
    pulse(3'b001); chk(3'd2, 1'b0, "R2 reach stage 2");
    arm = 1'b0; match = 3'b001; step(); match = '0;
    chk(3'd0, 1'b0, "R2 disarm beats terminal match");
    arm = 1'b1;
  endtask

  initial begin
    #35 rst_n = 1'b1;
    #3;
    t_reset();
    step();
    t_arm();
    t_chain();
    t_priority();
    t_consec();
    t_range();
    t_nomove();
    t_disarm_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule